// File: doc/BRIEF.md
# CW Keying and Transmit Control

This block is the control logic between an operator's keyboard, a CW tone detector and the transmitter of a Morse and radioteletype terminal. It lights a monitor LED and opens an audible sidetone gate when a tone is detected in CW receive or when the operator keys. It drives the keying switch and holds a push-to-talk line active for a programmable hang time after the last keying activity. It also steers a frequency-shift keying output between the received demodulated bit and the bit being sent.

The key and tone inputs are asynchronous and pass through a two-flop synchronizer. A small state machine with three states owns the push-to-talk line. HS_IDLE has the transmitter off. HS_KEYED is entered from HS_IDLE or HS_HANG whenever the key is down, and reloads the hang counter on every cycle. HS_HANG is entered from HS_KEYED when the key is released. It counts down once per `ms_tick` pulse and returns to HS_IDLE when the last tick of the hang time arrives. A key press during HS_HANG returns to HS_KEYED, so the full hang time restarts from the next release. The 800 Hz sidetone is made by dividing the system clock.

Top module: `cwk_ctrl`

## Requirements
- R1: While `rst_n` is low, `ptt`, `mon_led`, `mon_gate`, `key_sw` and `sidetone` are all 0.
- R2: With `mode_cw`=1 and the key up, `mon_led` and `mon_gate` equal `tone_in` three clock edges after `tone_in` changes.
- R3: With `mode_cw`=0 (RTTY), `tone_in` has no effect: `mon_led` and `mon_gate` stay 0 while the key is up.
- R4: In either mode, a key press makes `mon_led`, `mon_gate` and `key_sw` go to 1 on the same edge, the third clock edge after `key_in` rises.
- R5: `ptt` goes to 1 on the same edge as `key_sw` and stays 1 while the key is held, no matter how many `ms_tick` pulses arrive.
- R6: After the key is released, `ptt` stays 1 until exactly HANG_TICKS `ms_tick` pulses have been sampled in the hang state. It is 0 on the cycle after the last one.
- R7: A key press during the hang time cancels the countdown. The next release starts a full HANG_TICKS countdown.
- R8: While `mon_gate` is 1, `sidetone` is a square wave whose high and low phases each last CLK_HZ/(2*TONE_HZ) cycles. While the gate is closed, `sidetone` is 0.
- R9: `fsk_out` is registered with one cycle of latency. Its value is 1 (mark) when `mode_cw`=1, `tx_bit` when `mode_cw`=0 and `send_sel`=1, and `rx_bit` when `mode_cw`=0 and `send_sel`=0.
- R10: `key_sw` follows the synchronized key level. It returns to 0 on the third clock edge after `key_in` falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_in | input | 1 | Keyboard key-down, asynchronous, active high |
| tone_in | input | 1 | CW tone detector output, asynchronous |
| mode_cw | input | 1 | 1 = CW, 0 = RTTY |
| send_sel | input | 1 | 1 = FSK output carries the transmit bit |
| rx_bit | input | 1 | Received demodulated bit |
| tx_bit | input | 1 | Transmit bit |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| mon_led | output | 1 | Monitor LED drive |
| mon_gate | output | 1 | Sidetone oscillator gate |
| sidetone | output | 1 | 800 Hz sidetone square wave |
| key_sw | output | 1 | Keying switch drive |
| ptt | output | 1 | Transmit enable |
| fsk_out | output | 1 | Selected FSK bit |

## Verification
The hardest case to reach is a key press that arrives partway through the hang countdown. Checking it requires proof that the remaining count was discarded rather than carried over. The bench releases the key, delivers part of the hang ticks, presses and releases the key again, and then counts `ms_tick` pulses one at a time. It checks that `ptt` falls only after a full HANG_TICKS pulses. Ticks sent while the key is held show that the counter does not run in HS_KEYED. The sidetone period is measured by counting sampled cycles between edges while the key holds the gate open.

// File: rtl/cwk_pkg.sv
package cwk_pkg;
    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_KEYED = 2'd1,
        HS_HANG  = 2'd2
    } hang_state_t;
endpackage

// File: rtl/cwk_sync.sv
module cwk_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/cwk_hang.sv
module cwk_hang
    import cwk_pkg::*;
#(
    parameter int HANG_TICKS = 250,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_lvl,
    input  logic             ms_tick,
    output logic             ptt,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(HANG_TICKS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    hang_state_t state_q, state_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            HS_IDLE:  if (key_lvl) state_n = HS_KEYED;
            HS_KEYED: if (!key_lvl) state_n = HS_HANG;
            HS_HANG: begin
                if (key_lvl)                     state_n = HS_KEYED;
                else if (ms_tick && cnt == LAST) state_n = HS_IDLE;
            end
            default: state_n = HS_IDLE;
        endcase
    end

    // hang counter: held at full value while keyed, counts ticks in hang
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            cnt <= '0;
        else if (key_lvl)                      cnt <= LOAD;
        else if (state_q == HS_HANG && ms_tick) cnt <= cnt - LAST;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            HS_KEYED, HS_HANG: ptt = 1'b1;
            default:           ptt = 1'b0;
        endcase
    end
endmodule

// File: rtl/cwk_tone.sv
module cwk_tone #(
    parameter int HALF = 78125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic tone
);
    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DW-1:0] WRAP = DW'(HALF - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            tone  <= 1'b0;
        end else if (!gate) begin
            div_q <= '0;
            tone  <= 1'b0;
        end else if (div_q == WRAP) begin
            div_q <= '0;
            tone  <= ~tone;
        end else begin
            div_q <= div_q + DW'(1);
        end
    end
endmodule

// File: rtl/cwk_ctrl.sv
module cwk_ctrl #(
    parameter int CLK_HZ     = 125_000_000,
    parameter int TONE_HZ    = 800,
    parameter int HANG_TICKS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_in,
    input  logic tone_in,
    input  logic mode_cw,
    input  logic send_sel,
    input  logic rx_bit,
    input  logic tx_bit,
    input  logic ms_tick,
    output logic mon_led,
    output logic mon_gate,
    output logic sidetone,
    output logic key_sw,
    output logic ptt,
    output logic fsk_out
);
    localparam int CNT_W = $clog2(HANG_TICKS + 1);
    localparam int HALF  = CLK_HZ / (2 * TONE_HZ);

    logic [1:0]       sync_q;
    logic             key_s;
    logic             tone_s;
    logic [CNT_W-1:0] hang_cnt;

    cwk_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({key_in, tone_in}),
        .q     (sync_q)
    );
    assign key_s  = sync_q[1];
    assign tone_s = sync_q[0];

    // monitor and keying drive; detector masked in RTTY
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_led  <= 1'b0;
            mon_gate <= 1'b0;
            key_sw   <= 1'b0;
        end else begin
            mon_led  <= key_s | (mode_cw & tone_s);
            mon_gate <= key_s | (mode_cw & tone_s);
            key_sw   <= key_s;
        end
    end

    cwk_hang #(.HANG_TICKS(HANG_TICKS), .CNT_W(CNT_W)) u_hang (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_lvl (key_s),
        .ms_tick (ms_tick),
        .ptt     (ptt),
        .cnt     (hang_cnt)
    );

    cwk_tone #(.HALF(HALF)) u_tone (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (mon_gate),
        .tone  (sidetone)
    );

    // FSK steering: mark in CW, send/receive select in RTTY
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       fsk_out <= 1'b1;
        else if (mode_cw) fsk_out <= 1'b1;
        else              fsk_out <= send_sel ? tx_bit : rx_bit;
    end
endmodule

// File: rtl/cwk_chk.sv
module cwk_chk #(
    parameter int HANG_TICKS = 250,
    parameter int CNT_W      = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ms_tick,
    input logic             mode_cw,
    input logic             key_sw,
    input logic             mon_led,
    input logic             mon_gate,
    input logic             sidetone,
    input logic             ptt,
    input logic             fsk_out,
    input logic [CNT_W-1:0] hang_cnt
);
    AST_KEY_NEEDS_PTT: assert property (@(posedge clk) disable iff (!rst_n)
        key_sw |-> ptt); // R5
    AST_KEY_LIGHTS_LED: assert property (@(posedge clk) disable iff (!rst_n)
        key_sw |-> (mon_led && mon_gate)); // R4
    AST_PTT_DROP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ptt) |-> $past(ms_tick)); // R6
    AST_HANG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        hang_cnt <= CNT_W'(HANG_TICKS)); // R6
    AST_TONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_gate |=> !sidetone); // R8
    AST_FSK_MARK_CW: assert property (@(posedge clk) disable iff (!rst_n)
        mode_cw |=> fsk_out); // R9
endmodule

bind cwk_ctrl cwk_chk #(.HANG_TICKS(HANG_TICKS), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ms_tick  (ms_tick),
    .mode_cw  (mode_cw),
    .key_sw   (key_sw),
    .mon_led  (mon_led),
    .mon_gate (mon_gate),
    .sidetone (sidetone),
    .ptt      (ptt),
    .fsk_out  (fsk_out),
    .hang_cnt (hang_cnt)
);

// File: tb/sim_cwk_ctrl.sv
module sim_cwk_ctrl;
    localparam int HANG   = 4;
    localparam int CLKHZ  = 8000;
    localparam int TONEHZ = 800;
    localparam int HALF   = CLKHZ / (2 * TONEHZ);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, key_in, tone_in, mode_cw, send_sel, rx_bit, tx_bit, ms_tick;
    logic mon_led, mon_gate, sidetone, key_sw, ptt, fsk_out;
    int   errs = 0;
    int   checks = 0;
    bit   done = 1'b0;

    cwk_ctrl #(.CLK_HZ(CLKHZ), .TONE_HZ(TONEHZ), .HANG_TICKS(HANG)) u0 (
        .clk(clk), .rst_n(rst_n), .key_in(key_in), .tone_in(tone_in),
        .mode_cw(mode_cw), .send_sel(send_sel), .rx_bit(rx_bit),
        .tx_bit(tx_bit), .ms_tick(ms_tick), .mon_led(mon_led),
        .mon_gate(mon_gate), .sidetone(sidetone), .key_sw(key_sw),
        .ptt(ptt), .fsk_out(fsk_out)
    );

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_int(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_tick();
        ms_tick = 1'b1;
        wait_n(1);
        ms_tick = 1'b0;
    endtask

    // key already released long enough for the hang state: count down fully
    task automatic hang_run(string req);
        for (int k = 1; k <= HANG; k++) begin
            pulse_tick();
            chk(req, ptt, k < HANG);
            wait_n(2);
            chk(req, ptt, k < HANG);
        end
    endtask

    initial begin
        rst_n = 1'b0; key_in = 1'b0; tone_in = 1'b0; mode_cw = 1'b1;
        send_sel = 1'b0; rx_bit = 1'b0; tx_bit = 1'b0; ms_tick = 1'b0;
        wait_n(3);
        chk("R1 ptt", ptt, 1'b0);
        chk("R1 led", mon_led, 1'b0);
        chk("R1 gate", mon_gate, 1'b0);
        chk("R1 key_sw", key_sw, 1'b0);
        chk("R1 sidetone", sidetone, 1'b0);
        rst_n = 1'b1;
        wait_n(2);

        // R2 / R3 sweep of mode x tone with key up
        for (int m = 0; m < 2; m++) begin
            for (int t = 0; t < 2; t++) begin
                mode_cw = m[0]; tone_in = t[0];
                wait_n(4);
                chk(m ? "R2 led" : "R3 led", mon_led, m[0] & t[0]);
                chk(m ? "R2 gate" : "R3 gate", mon_gate, m[0] & t[0]);
                chk(m ? "R2 ptt" : "R3 ptt", ptt, 1'b0);
            end
        end
        tone_in = 1'b0; mode_cw = 1'b1;
        wait_n(4);

        // R2 latency: tone edge visible on third edge
        tone_in = 1'b1;
        wait_n(2);
        chk("R2 latency early", mon_led, 1'b0);
        wait_n(1);
        chk("R2 latency", mon_led, 1'b1);
        tone_in = 1'b0;
        wait_n(4);

        // R4 / R5 key press
        key_in = 1'b1;
        wait_n(2);
        chk("R4 early led", mon_led, 1'b0);
        chk("R4 early key_sw", key_sw, 1'b0);
        chk("R5 early ptt", ptt, 1'b0);
        wait_n(1);
        chk("R4 led", mon_led, 1'b1);
        chk("R4 gate", mon_gate, 1'b1);
        chk("R4 key_sw", key_sw, 1'b1);
        chk("R5 ptt", ptt, 1'b1);

        // R8 sidetone period while gate open
        begin
            int w = 0;
            int hi = 0;
            int lo = 0;
            while (sidetone !== 1'b1 && w < 40) begin wait_n(1); w++; end
            while (sidetone === 1'b1 && hi < 40) begin wait_n(1); hi++; end
            while (sidetone === 1'b0 && lo < 40) begin wait_n(1); lo++; end
            chk_int("R8 high phase", hi, HALF);
            chk_int("R8 low phase", lo, HALF);
        end

        // R5 ticks while held do not count
        for (int i = 0; i < HANG + 2; i++) begin
            pulse_tick();
            wait_n(1);
        end
        chk("R5 held ptt", ptt, 1'b1);

        // R10 release
        key_in = 1'b0;
        wait_n(2);
        chk("R10 key_sw early", key_sw, 1'b1);
        wait_n(1);
        chk("R10 key_sw", key_sw, 1'b0);
        chk("R10 led", mon_led, 1'b0);
        chk("R6 ptt after release", ptt, 1'b1);
        wait_n(2);
        chk("R8 gate closed", sidetone, 1'b0);
        hang_run("R6");

        // R7 re-key during hang
        key_in = 1'b1; wait_n(3);
        chk("R7 ptt", ptt, 1'b1);
        key_in = 1'b0; wait_n(4);
        pulse_tick(); wait_n(1);
        pulse_tick(); wait_n(1);
        chk("R7 mid hang", ptt, 1'b1);
        key_in = 1'b1; wait_n(3);
        key_in = 1'b0; wait_n(4);
        hang_run("R7");

        // R4 key in RTTY mode
        mode_cw = 1'b0; tone_in = 1'b1;
        key_in = 1'b1; wait_n(3);
        chk("R4 rtty led", mon_led, 1'b1);
        chk("R4 rtty key_sw", key_sw, 1'b1);
        key_in = 1'b0; wait_n(4);
        chk("R3 rtty after key", mon_led, 1'b0);
        hang_run("R6 rtty");
        tone_in = 1'b0;

        // R9 FSK sweep
        for (int v = 0; v < 16; v++) begin
            mode_cw = v[3]; send_sel = v[2]; tx_bit = v[1]; rx_bit = v[0];
            wait_n(1);
            chk("R9 fsk", fsk_out, v[3] ? 1'b1 : (v[2] ? v[1] : v[0]));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule